// File: doc/BRIEF.md
# Causal Neighborhood Line Buffer

This block sits between a raster-order grayscale pixel source and the prediction stage of a lossless image encoder. Each accepted 8-bit pixel leaves the block together with its four causal neighbors: the pixel to its left, the pixel above it, the pixel above-left and the pixel above-right. The row and column of the pixel and a flag marking the final pixel of the image travel with it. Image width and height are runtime inputs. They are held constant for the whole of a frame and may change between frames.

One earlier row is kept in on-chip storage. The upper pixel and the upper-right pixel are read from that row at the current column and at the column after it. The upper-left pixel is not read from storage. It is the upper pixel of the previous output, which stays in the output register. Outside the image borders, fixed substitution rules take the place of neighbors that do not exist. Both sides use a ready/valid handshake. Back-pressure on the output side stalls the input side without loss or duplication. After the last pixel of a frame, the position counters wrap so that the next frame can follow at once.

Top module: `nbr_line_window`

## Requirements
- R1: Outputs appear one per accepted input, in the same order, with out_x equal to the input pixel and out_row/out_col counting raster positions from (0,0). No extra output is produced.
- R2: For a pixel at row r ≥ 1 and column c with 0 < c < width-1, the neighbors are as follows. A is pixel (r,c-1), B is (r-1,c), C is (r-1,c-1) and D is (r-1,c+1).
- R3: On row 0, B, C and D are 0. A follows R2 when c > 0, and follows R4 when c = 0.
- R4: In column 0, A equals B of the same pixel. C equals the A value used at column 0 of the previous row. That value is pixel (r-2,0) when r ≥ 2, and 0 when r is 0 or 1.
- R5: In the last column (c = width-1) on rows r ≥ 1, D equals B.
- R6: Degenerate shapes are handled by the same rules, including width 1, height 1 and a 1x1 image. With width 1, A = B = D, and C follows R4.
- R7: out_last is 1 exactly on pixel (height-1, width-1). The next accepted pixel becomes (0,0) of a new frame and takes the row-0 rules.
- R8: The width may be any value from 1 to MAX_W and the height any value from 1 to MAX_H, chosen at runtime. They may change between frames without a reset.
- R9: While out_valid=1 and out_ready=0, every output field is held and in_ready is 0. While out_valid=0, in_ready is 1.
- R10: After reset out_valid is 0 and in_ready is 1, and the first accepted pixel is reported as row 0, column 0. This also holds after a reset in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | CFGW_W | Image width in pixels (1..MAX_W), constant within a frame |
| cfg_height | input | CFGH_W | Image height in rows (1..MAX_H), constant within a frame |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_pix | input | 8 | Input pixel, raster order |
| out_valid | output | 1 | Output window present |
| out_ready | input | 1 | Consumer takes the window this cycle |
| out_x | output | 8 | Current pixel |
| out_a | output | 8 | Left neighbor |
| out_b | output | 8 | Upper neighbor |
| out_c | output | 8 | Upper-left neighbor |
| out_d | output | 8 | Upper-right neighbor |
| out_row | output | ROW_W | Row index of the current pixel |
| out_col | output | COL_W | Column index of the current pixel |
| out_last | output | 1 | Current pixel is the last of the frame |

## Verification
The bench builds the block with MAX_W = 16 and MAX_H = 16. With these values a full-width frame needs only 48 pixels. A full-width frame is the case where the upper-right read address reaches the top of the row store and the counter wrap is exercised. The same small row store also lets one run cover many shapes back to back without a reset. The shapes include 1-wide, 1-tall and 1x1 frames, and each frame has its own output-stall pattern and input-gap pattern.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int PIX_W     = 8;
    localparam int COL_LIMIT = 4096;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        pix_t x;
        pix_t a;
        pix_t b;
        pix_t c;
        pix_t d;
    } nbr_set_t;
endpackage

// File: rtl/nbr_raster_pos.sv
module nbr_raster_pos #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 10,
    parameter int CFGW_W = 11,
    parameter int CFGH_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [CFGW_W-1:0] cfg_width,
    input  logic [CFGH_W-1:0] cfg_height,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              first_col_o,
    output logic              first_row_o,
    output logic              last_col_o,
    output logic              last_row_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;
    logic at_last_col, at_last_row;

    always_comb begin
        at_last_col = (CFGW_W'(pos_q.col) + CFGW_W'(1)) == cfg_width;
        at_last_row = (CFGH_W'(pos_q.row) + CFGH_W'(1)) == cfg_height;
        pos_d       = pos_q;
        if (adv) begin
            if (at_last_col) begin
                pos_d.col = '0;
                pos_d.row = at_last_row ? '0 : pos_q.row + ROW_W'(1);
            end else begin
                pos_d.col = pos_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign col_o       = pos_q.col;
    assign row_o       = pos_q.row;
    assign first_col_o = (pos_q.col == '0);
    assign first_row_o = (pos_q.row == '0);
    assign last_col_o  = at_last_col;
    assign last_row_o  = at_last_row;

    // R7: the column wraps to zero after the last column is taken
    assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv && at_last_col |=> pos_q.col == '0);

    // R7: the frame wraps to the origin after its final pixel
    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adv && at_last_col && at_last_row |=> pos_q.row == '0);

    // R1: within a row the column steps by exactly one per accepted pixel
    assert_col_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !at_last_col |=> pos_q.col == $past(pos_q.col) + COL_W'(1));
endmodule

// File: rtl/nbr_row_store.sv
module nbr_row_store #(
    parameter int MAX_W = 1024,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_addr,
    input  nbr_pkg::pix_t    wr_data,
    input  logic [COL_W-1:0] rd_addr,
    output nbr_pkg::pix_t    rd_up,
    output nbr_pkg::pix_t    rd_up_right
);
    import nbr_pkg::*;

    localparam bit POW2 = ((1 << COL_W) == MAX_W);

    pix_t             mem [MAX_W];
    logic [COL_W-1:0] ahead_addr;

    generate
        if (POW2) begin : g_wrap
            // the address wraps on its own; the wrapped read only happens in the last column, where D is replaced
            assign ahead_addr = rd_addr + COL_W'(1);
        end else begin : g_clamp
            assign ahead_addr = (rd_addr == COL_W'(MAX_W - 1)) ? rd_addr : rd_addr + COL_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_up       = mem[rd_addr];
    assign rd_up_right = mem[ahead_addr];
endmodule

// File: rtl/nbr_window.sv
module nbr_window #(
    parameter int COL_W = 10,
    parameter int ROW_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                out_ready,
    input  nbr_pkg::pix_t       pix,
    input  logic [COL_W-1:0]    col,
    input  logic [ROW_W-1:0]    row,
    input  logic                first_col,
    input  logic                first_row,
    input  logic                last_col,
    input  logic                last_row,
    input  nbr_pkg::pix_t       up,
    input  nbr_pkg::pix_t       up_right,
    output logic                valid_o,
    output nbr_pkg::nbr_set_t   set_o,
    output logic [ROW_W-1:0]    row_o,
    output logic [COL_W-1:0]    col_o,
    output logic                last_o
);
    import nbr_pkg::*;

    typedef struct packed {
        logic             valid;
        nbr_set_t         set;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             last;
        pix_t             row_start_a;
    } win_t;

    win_t w_d, w_q;
    pix_t b_n, a_n, c_n, d_n;

    always_comb begin
        // the payload stays in the register after hand-off, so it still holds the previous pixel and its upper neighbor
        b_n = first_row ? '0 : up;
        a_n = first_col ? b_n : w_q.set.x;
        c_n = first_row ? '0 : (first_col ? w_q.row_start_a : w_q.set.b);
        d_n = first_row ? '0 : (last_col ? b_n : up_right);

        w_d = w_q;
        if (adv) begin
            w_d.valid = 1'b1;
            w_d.set   = '{x: pix, a: a_n, b: b_n, c: c_n, d: d_n};
            w_d.row   = row;
            w_d.col   = col;
            w_d.last  = last_col && last_row;
            if (first_col) w_d.row_start_a = a_n;
        end else if (out_ready) begin
            w_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign valid_o = w_q.valid;
    assign set_o   = w_q.set;
    assign row_o   = w_q.row;
    assign col_o   = w_q.col;
    assign last_o  = w_q.last;

    // R9: a stalled window keeps every field
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.valid && !out_ready |=> w_q.valid && $stable(w_q.set) && $stable(w_q.row)
                                     && $stable(w_q.col) && $stable(w_q.last));

    // R1: no new window is loaded over a stalled one
    assert_no_overwrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.valid && !out_ready |-> !adv);
endmodule

// File: rtl/nbr_line_window.sv
module nbr_line_window #(
    parameter int  MAX_W  = 1024,
    parameter int  MAX_H  = 1024,
    localparam int COL_W  = $clog2(MAX_W),
    localparam int ROW_W  = $clog2(MAX_H),
    localparam int CFGW_W = $clog2(MAX_W + 1),
    localparam int CFGH_W = $clog2(MAX_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFGW_W-1:0] cfg_width,
    input  logic [CFGH_W-1:0] cfg_height,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_x,
    output logic [7:0]        out_a,
    output logic [7:0]        out_b,
    output logic [7:0]        out_c,
    output logic [7:0]        out_d,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic              out_last
);
    import nbr_pkg::*;

    logic             adv;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic             first_col, first_row, last_col, last_row;
    pix_t             up_pix, up_right_pix;
    nbr_set_t         win_set;

    assign in_ready = !out_valid || out_ready;
    assign adv      = in_valid && in_ready;

    nbr_raster_pos #(
        .COL_W (COL_W),
        .ROW_W (ROW_W),
        .CFGW_W(CFGW_W),
        .CFGH_W(CFGH_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .col_o      (cur_col),
        .row_o      (cur_row),
        .first_col_o(first_col),
        .first_row_o(first_row),
        .last_col_o (last_col),
        .last_row_o (last_row)
    );

    nbr_row_store #(
        .MAX_W(MAX_W),
        .COL_W(COL_W)
    ) u_store (
        .clk        (clk),
        .wr_en      (adv),
        .wr_addr    (cur_col),
        .wr_data    (in_pix),
        .rd_addr    (cur_col),
        .rd_up      (up_pix),
        .rd_up_right(up_right_pix)
    );

    nbr_window #(
        .COL_W(COL_W),
        .ROW_W(ROW_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .out_ready(out_ready),
        .pix      (in_pix),
        .col      (cur_col),
        .row      (cur_row),
        .first_col(first_col),
        .first_row(first_row),
        .last_col (last_col),
        .last_row (last_row),
        .up       (up_pix),
        .up_right (up_right_pix),
        .valid_o  (out_valid),
        .set_o    (win_set),
        .row_o    (out_row),
        .col_o    (out_col),
        .last_o   (out_last)
    );

    assign out_x = win_set.x;
    assign out_a = win_set.a;
    assign out_b = win_set.b;
    assign out_c = win_set.c;
    assign out_d = win_set.d;

    // R9: an empty output side always takes input
    assert_ready_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R3: the first row sees zero above
    assert_top_row_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_row == '0 |-> out_b == '0 && out_c == '0 && out_d == '0);

    // R4: the first column copies the upper pixel into the left neighbor
    assert_first_col_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_col == '0 |-> out_a == out_b);

    // R4: the second row starts with the upper-left taken from a zero row start
    assert_second_row_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_col == '0 && out_row == ROW_W'(1) |-> out_c == '0);

    // R5: the last column repeats the upper pixel as upper-right
    assert_last_col_d_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (CFGW_W'(out_col) + CFGW_W'(1)) == cfg_width |-> out_d == out_b);

    // R7: the last flag marks only the final pixel of the frame
    assert_last_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> (CFGW_W'(out_col) + CFGW_W'(1)) == cfg_width
                                  && (CFGH_W'(out_row) + CFGH_W'(1)) == cfg_height);

    // R8: reported indices stay inside the configured frame
    assert_col_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> CFGW_W'(out_col) < cfg_width);
endmodule

// File: tb/tb_nbr_line_window.sv
module tb_nbr_line_window;
    localparam int MAX_W = 16;
    localparam int MAX_H = 16;
    localparam int COL_W = $clog2(MAX_W);
    localparam int ROW_W = $clog2(MAX_H);
    localparam int CW    = $clog2(MAX_W + 1);
    localparam int CH    = $clog2(MAX_H + 1);

    // frame table: width, height, pixel pattern, mode (bit0 output stalls, bit1 input gaps)
    localparam int NV = 9;
    localparam int VW [NV] = '{4, 8, 1, 6, 1, 5, 2, 16, 3};
    localparam int VH [NV] = '{4, 8, 6, 1, 1, 3, 4, 3, 16};
    localparam int VP [NV] = '{0, 1, 2, 1, 0, 2, 1, 1, 0};
    localparam int VM [NV] = '{0, 1, 2, 3, 0, 3, 1, 3, 2};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_width = '0;
    logic [CH-1:0] cfg_height = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_pix = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_x, out_a, out_b, out_c, out_d;
    logic [ROW_W-1:0] out_row;
    logic [COL_W-1:0] out_col;
    logic          out_last;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nbr_line_window #(.MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
        .out_row(out_row), .out_col(out_col), .out_last(out_last)
    );

    function automatic logic [7:0] pix(input int pat, input int r, input int c);
        case (pat)
            0:       return 8'((r * 16 + c * 3 + 1) & 255);
            1:       return 8'((r * 37 + c * 101 + r * c * 13 + 7) & 255);
            default: return ((r + c) % 2 == 1) ? 8'd200 : 8'd17;
        endcase
    endfunction

    // expected {x,a,b,c,d} straight from the neighbor rules
    function automatic logic [39:0] expect_set(input int pat, input int w, input int r, input int c);
        logic [7:0] ex, ea, eb, ec, ed;
        ex = pix(pat, r, c);
        eb = (r == 0) ? 8'd0 : pix(pat, r - 1, c);
        ea = (c == 0) ? eb : pix(pat, r, c - 1);
        if (r == 0)      ec = 8'd0;
        else if (c == 0) ec = (r >= 2) ? pix(pat, r - 2, 0) : 8'd0;
        else             ec = pix(pat, r - 1, c - 1);
        if (r == 0)          ed = 8'd0;
        else if (c == w - 1) ed = eb;
        else                 ed = pix(pat, r - 1, c + 1);
        return {ex, ea, eb, ec, ed};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input int w, input int h, input int pat, input int mode, input string size_tag);
        int sent = 0;
        int got = 0;
        int cyc = 0;
        int total = w * h;
        bit stalled = 1'b0;
        logic [39:0] held;
        string tag;
        cfg_width  = CW'(w);
        cfg_height = CH'(h);
        while (got < total && cyc < 4000) begin
            @(negedge clk);
            in_valid  = (sent < total) && !(mode[1] && (cyc % 5 == 2));
            in_pix    = pix(pat, sent / w, sent % w);
            out_ready = !(mode[0] && (cyc % 3 == 1));
            #1;
            if (stalled) begin
                // R9: the held window must not move
                check({out_x, out_a, out_b, out_c, out_d} == held && out_valid, "R9", "stall hold",
                      {out_x, out_a, out_b, out_c, out_d}, held);
            end
            if (out_valid && !out_ready)
                check(in_ready == 1'b0, "R9", "in_ready during stall", in_ready, 0);
            if (out_valid && out_ready) begin
                int r = got / w;
                int c = got % w;
                logic [39:0] e = expect_set(pat, w, r, c);
                if (w == 1 || h == 1)  tag = "R6";
                else if (r == 0)       tag = "R3";
                else if (c == 0)       tag = "R4";
                else if (c == w - 1)   tag = "R5";
                else                   tag = "R2";
                check({out_x, out_a, out_b, out_c, out_d} == e, tag, "neighbors",
                      {out_x, out_a, out_b, out_c, out_d}, e);
                check(int'(out_row) == r && int'(out_col) == c, "R1", "position",
                      {out_row, out_col}, (r << COL_W) | c);
                check(out_last == (got == total - 1), "R7", "last flag", out_last, got == total - 1);
                got++;
            end
            if (in_valid && in_ready) sent++;
            stalled = out_valid && !out_ready;
            held    = {out_x, out_a, out_b, out_c, out_d};
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        // R1 no duplicate; size_tag marks R8 runtime size changes
        check(got == total && !out_valid, size_tag, "frame complete, nothing extra",
              got, total);
    endtask

    initial begin
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "reset state", {out_valid, in_ready}, 2'b01);
        rst_n = 1'b1;

        // table walk, frames back to back with no reset between size changes
        for (int v = 0; v < NV; v++)
            run_frame(VW[v], VH[v], VP[v], VM[v], (v == 0) ? "R1" : "R8");

        // directed: reset in the middle of a frame
        cfg_width  = CW'(5);
        cfg_height = CH'(5);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = 8'(k * 9);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "mid-frame reset state",
              {out_valid, in_ready}, 2'b01);
        @(negedge clk);
        rst_n = 1'b1;
        run_frame(3, 3, 1, 1, "R10");

        // directed: 1x1 frame twice in a row, the last flag on every pixel
        run_frame(1, 1, 2, 3, "R6");
        run_frame(1, 1, 0, 0, "R7");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule